// File: doc/BRIEF.md
# UART Line Break Detector

This block watches a UART receive line that has already been sampled at the bit rate and decides when the line has been held low for longer than one whole character could last. When that happens it gives one single-cycle event and raises a level that stays up for as long as the line stays low. Character reception and buffering belong to other blocks. This one only looks at the line, on the clock cycles marked by a bit-rate tick.

The length of the longest legal low run follows from the current framing settings. That run is one start bit, five to eight data bits, an optional parity bit and one or two stop bits. A low run one tick longer than that counts as a break. A long break gives exactly one event. After a break ends, the detector stays disarmed until the line has been high for a set number of consecutive bit ticks. A glitchy line that falls again too soon therefore cannot start a second event.

The controller has four states. ST_IDLE is armed, with the line high. ST_LOW_RUN counts consecutive low ticks. ST_BREAK means a break is in progress. ST_RECOVER means the break has ended and the detector is waiting for enough high time to re-arm. The transitions are:
- ST_IDLE to ST_LOW_RUN on a low tick.
- ST_LOW_RUN to ST_IDLE on a high tick.
- ST_LOW_RUN to ST_BREAK on the low tick that reaches the threshold.
- ST_BREAK to ST_RECOVER on a high tick.
- ST_BREAK to ST_IDLE directly when a single high tick is enough to re-arm.
- ST_RECOVER to ST_IDLE once the required run of high ticks is complete.

Top module: `brk_detect`

## Requirements
- R1: Out of reset, brk_pulse and brk_active are both 0.
- R2: The frame length in bits is 1 + D + P + S. Here D = 5 + data_len_code (code 0 means 5 data bits, code 3 means 8), P = parity_en, and S = 1 + two_stop. A break is recognised after frame + 1 consecutive ticks with rx_line at 0. A low run of exactly frame ticks followed by a high tick gives no event.
- R3: brk_pulse is 1 for exactly one clock cycle. That cycle is the one right after the clock cycle whose tick completes the qualifying low run.
- R4: brk_active rises in the same cycle as brk_pulse. It stays 1 until the first tick that samples rx_line at 1, and it is 0 in the cycle after that tick.
- R5: One break gives exactly one event, however many further low ticks follow. The low-run count saturates at the threshold and never wraps.
- R6: After a break ends, the detector re-arms only after REARM_BITS consecutive high ticks (default 2). Low ticks before that point reset the high-run count and are not counted toward a new break.
- R7: rx_line is used only in cycles where bit_tick is 1. Changes in other cycles have no effect on either output.
- R8: A high tick during a low run that is still below the threshold restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Receive line, already sampled |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| data_len_code | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Two stop bits when 1, one when 0 |
| brk_pulse | output | 1 | Single-cycle break event |
| brk_active | output | 1 | High while the break is in progress |

## Verification
A low-run count that is off by one moves brk_pulse to the tick before or after the expected one, in every one of the sixteen framing settings. A threshold computed wrongly for one setting shows up the same way, but only for that setting. A state that fails to leave ST_BREAK or ST_RECOVER at the right tick shows up within one tick: either a second pulse appears during a long low run, or brk_active does not fall after the first high tick, or a new break is reported before the required high run. All of these are visible at the ports in the cycle that follows the deciding tick.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW_RUN,
        ST_BREAK,
        ST_RECOVER
    } brk_state_t;

    localparam int DATA_MIN_BITS = 5;

endpackage

// File: rtl/brk_frame_len.sv
// Break threshold: the low-tick count that is one longer than a full frame.
module brk_frame_len #(
    parameter int CODE_W   = 2,
    parameter int DATA_MIN = 5,
    parameter int CNT_W    = 4
) (
    input  logic [CODE_W-1:0] data_len_code,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic [CNT_W-1:0]  thresh
);
    // start bit + one stop bit + the extra tick that makes it "longer than"
    localparam int FIXED_PART = DATA_MIN + 3;

    always_comb begin
        thresh = CNT_W'(FIXED_PART)
               + CNT_W'(data_len_code)
               + CNT_W'(parity_en)
               + CNT_W'(two_stop);
    end
endmodule

// File: rtl/brk_sat_counter.sv
// Saturating up-counter with clear priority and a hit flag for the increment
// that reaches the limit.
module brk_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_plus;
    logic         below;

    always_comb begin
        cnt_plus = cnt + W'(1);
        below    = (cnt < limit);
        hit      = inc && !clr && below && (cnt_plus == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && below) begin
            cnt <= cnt_plus;
        end
    end
endmodule

// File: rtl/brk_detect.sv
module brk_detect
    import brk_pkg::*;
#(
    parameter int CODE_W      = 2,
    parameter int REARM_BITS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic [CODE_W-1:0] data_len_code,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic              brk_pulse,
    output logic              brk_active
);
    localparam int MAX_THRESH = DATA_MIN_BITS + 3 + (2**CODE_W - 1) + 2;
    localparam int CNT_W      = $clog2(MAX_THRESH + 1);
    localparam int REARM_W    = $clog2(REARM_BITS + 1);

    brk_state_t state_q, state_d;

    logic              lo_tick, hi_tick;
    logic [CNT_W-1:0]  thresh;
    logic [CNT_W-1:0]  lo_cnt;
    logic              lo_hit, lo_inc;
    logic [REARM_W-1:0] hi_cnt;
    logic              rearm_hit, hi_inc;

    always_comb begin
        lo_tick = bit_tick && !rx_line;
        hi_tick = bit_tick &&  rx_line;
        lo_inc  = lo_tick && (state_q != ST_RECOVER);
        hi_inc  = hi_tick && ((state_q == ST_BREAK) || (state_q == ST_RECOVER));
    end

    brk_frame_len #(
        .CODE_W   (CODE_W),
        .DATA_MIN (DATA_MIN_BITS),
        .CNT_W    (CNT_W)
    ) u_len (
        .data_len_code (data_len_code),
        .parity_en     (parity_en),
        .two_stop      (two_stop),
        .thresh        (thresh)
    );

    brk_sat_counter #(.W(CNT_W)) u_low_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hi_tick),
        .inc   (lo_inc),
        .limit (thresh),
        .cnt   (lo_cnt),
        .hit   (lo_hit)
    );

    brk_sat_counter #(.W(REARM_W)) u_high_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lo_tick),
        .inc   (hi_inc),
        .limit (REARM_W'(REARM_BITS)),
        .cnt   (hi_cnt),
        .hit   (rearm_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lo_tick) state_d = lo_hit ? ST_BREAK : ST_LOW_RUN;
            end
            ST_LOW_RUN: begin
                if (hi_tick)     state_d = ST_IDLE;
                else if (lo_hit) state_d = ST_BREAK;
            end
            ST_BREAK: begin
                if (hi_tick) state_d = rearm_hit ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (rearm_hit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pulse  <= 1'b0;
            brk_active <= 1'b0;
        end else begin
            brk_pulse  <= (state_q != ST_BREAK) && (state_d == ST_BREAK);
            brk_active <= (state_d == ST_BREAK);
        end
    end
endmodule

// File: rtl/brk_detect_chk.sv
module brk_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_line,
    input logic bit_tick,
    input logic brk_pulse,
    input logic brk_active
);
    // R3: event lasts one cycle
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    // R4: the event comes with the active level
    p_pulse_with_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> brk_active);

    // R4: active rises only together with an event
    p_rise_needs_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_active) |-> brk_pulse);

    // R4, R7: active falls only after a tick that sampled the line high
    p_fall_needs_high_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_active) |-> ($past(bit_tick) && $past(rx_line)));

    // R5: no second event while a break is already active
    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> !$past(brk_active));

    // R7: a break begins only on a tick that sampled the line low
    p_rise_needs_low_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_active) |-> ($past(bit_tick) && !$past(rx_line)));
endmodule

bind brk_detect brk_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .bit_tick   (bit_tick),
    .brk_pulse  (brk_pulse),
    .brk_active (brk_active)
);

// File: tb/brk_detect_test.sv
`timescale 1ns/1ps
module brk_detect_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_line;
    logic       bit_tick;
    logic [1:0] data_len_code;
    logic       parity_en;
    logic       two_stop;
    logic       brk_pulse;
    logic       brk_active;

    int total = 0;
    int bad   = 0;
    int npulse = 0;
    bit finished = 0;

    localparam int REARM = 2;

    always #2 clk = ~clk;

    brk_detect uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_line       (rx_line),
        .bit_tick      (bit_tick),
        .data_len_code (data_len_code),
        .parity_en     (parity_en),
        .two_stop      (two_stop),
        .brk_pulse     (brk_pulse),
        .brk_active    (brk_active)
    );

    always @(negedge clk) if (rst_n && brk_pulse) npulse++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One tick with line value v. Outputs are sampled in the cycle after the tick.
    task automatic tk(input logic v, output logic p, output logic a);
        @(negedge clk);
        rx_line  = v;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        p = brk_pulse;
        a = brk_active;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic p, a;
        int p0, frame, thr;
        rst_n = 1'b0; rx_line = 1'b1; bit_tick = 1'b0;
        data_len_code = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse after reset", brk_pulse, 0);
        chk("R1 active after reset", brk_active, 0);

        for (int code = 0; code < 4; code++) begin
            for (int par = 0; par < 2; par++) begin
                for (int st = 0; st < 2; st++) begin
                    data_len_code = code[1:0];
                    parity_en     = par[0];
                    two_stop      = st[0];
                    frame = 1 + 5 + code + par + 1 + st;
                    thr   = frame + 1;
                    tk(1'b1, p, a);

                    // R2: a full frame of low is still not a break
                    p0 = npulse;
                    for (int k = 1; k <= frame; k++) begin
                        tk(1'b0, p, a);
                        chk("R2 frame-long low", p, 0);
                    end
                    tk(1'b1, p, a);
                    chk("R2 no event for frame-long low", npulse - p0, 0);
                    chk("R2 active stays low", a, 0);

                    // R8: high tick restarts a short low run
                    for (int k = 1; k < thr; k++) tk(1'b0, p, a);
                    tk(1'b1, p, a);
                    for (int k = 1; k < thr; k++) begin
                        tk(1'b0, p, a);
                        chk("R8 count restarted", p, 0);
                    end
                    tk(1'b1, p, a);

                    // R3/R4: the break itself
                    p0 = npulse;
                    for (int k = 1; k <= thr; k++) begin
                        tk(1'b0, p, a);
                        chk("R3 pulse timing", p, (k == thr) ? 1 : 0);
                        chk("R4 active level", a, (k == thr) ? 1 : 0);
                    end
                    // R5: long break, no further events
                    for (int k = 0; k < 20; k++) begin
                        tk(1'b0, p, a);
                        chk("R5 no repeat pulse", p, 0);
                        chk("R5 active held", a, 1);
                    end
                    // R7: line changes without a tick are ignored
                    @(negedge clk); rx_line = 1'b1;
                    repeat (3) @(negedge clk);
                    chk("R7 untimed high ignored", brk_active, 1);
                    rx_line = 1'b0;
                    @(negedge clk);
                    chk("R5 single event per break", npulse - p0, 1);

                    // R4: ends on first high tick
                    tk(1'b1, p, a);
                    chk("R4 active falls after high tick", a, 0);

                    // R6: no re-arm until REARM consecutive high ticks
                    p0 = npulse;
                    for (int k = 0; k < thr + 3; k++) tk(1'b0, p, a);
                    for (int k = 1; k < REARM; k++) tk(1'b1, p, a);
                    for (int k = 0; k < thr + 1; k++) tk(1'b0, p, a);
                    chk("R6 no event before re-arm", npulse - p0, 0);
                    chk("R6 active during recovery", a, 0);
                    for (int k = 0; k < REARM; k++) tk(1'b1, p, a);
                    for (int k = 1; k <= thr; k++) begin
                        tk(1'b0, p, a);
                        chk("R6 event after re-arm", p, (k == thr) ? 1 : 0);
                    end
                    for (int k = 0; k < REARM; k++) tk(1'b1, p, a);
                    chk("R4 idle after re-arm", a, 0);
                end
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule